// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block keeps a 64-bit running sum, stored as a low 32-bit half and a high 32-bit half, and updates it in a single cycle from a stream of commands. Each command carries two signed 32-bit operands and an operation code. The operation either adds the operand product to the sum, subtracts it, or reads the low half and clears the whole sum. The product is taken modulo 2^32 and then sign-extended to 64 bits before it meets the accumulator. The sum wraps modulo 2^64 and raises no flag.

Commands arrive on a valid/ready port. Read-and-clear results leave through a one-entry valid/ready result port. While a result is waiting and the consumer holds `res_ready` low, `cmd_ready` stays low, so every command type stalls until the result is taken. A separate plain write path loads either half directly, in the way a control processor writes special registers. Both halves are visible at all times on plain outputs.

Top module: `mac_acc_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, both halves read zero, `res_valid` is low and `cmd_ready` is high.
- R2: An accepted command with `cmd_op` = 0 adds the low 32 bits of the signed product `cmd_a * cmd_b`, sign-extended to 64 bits, to the sum `{acc_hi, acc_lo}`.
- R3: An accepted command with `cmd_op` = 1 subtracts that same sign-extended 32-bit product from the sum.
- R4: An accepted command with `cmd_op` = 2 presents the low half as it stood before the command on `res_data` with `res_valid` high in the next cycle, and leaves both halves at zero.
- R5: Every accepted command updates the halves at the accepting clock edge, so a command accepted in the very next cycle acts on the updated sum.
- R6: A command is accepted when `cmd_valid` and `cmd_ready` are both high; `cmd_ready` is low exactly while `res_valid` is high and `res_ready` is low, and during that time `res_valid` and `res_data` hold their values and the sum does not change through the command port.
- R7: With no accepted command, `wr_lo_en` loads `wr_data` into the low half and `wr_hi_en` loads it into the high half; both enables together load both halves; a half whose enable is low keeps its value.
- R8: When a command is accepted in the same cycle as a half write, the command's effect is applied and the half write is discarded.
- R9: An accepted command with `cmd_op` = 3 is reserved: it changes neither half and produces no result.
- R10: Sum arithmetic wraps modulo 2^64 with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 read-and-clear, 3 reserved |
| cmd_a | input | 32 | First signed operand |
| cmd_b | input | 32 | Second signed operand |
| res_valid | output | 1 | Read-and-clear result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Low half captured by read-and-clear |
| wr_lo_en | input | 1 | Load low half from `wr_data` |
| wr_hi_en | input | 1 | Load high half from `wr_data` |
| wr_data | input | 32 | Value for a half write |
| acc_lo | output | 32 | Low half of the sum |
| acc_hi | output | 32 | High half of the sum |

## Verification
The assertions assume the consumer follows the valid/ready rules on the result port and that inputs are known whenever reset is low, so `cmd_op` never carries an unknown value in a cycle where `cmd_valid` is high. The bench drives all inputs on the falling edge and returns `cmd_valid` and both write enables to zero between operations, except in the back-pressure and priority cases where it deliberately holds or overlaps them. Expected sums come from a 64-bit model that applies the truncate-and-sign-extend rule only to commands the bench has seen accepted.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MAC_ADD  = 2'd0,
    MAC_SUB  = 2'd1,
    MAC_RDCL = 2'd2,
    MAC_RSVD = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
// Truncated signed product: keep DATA_W low bits, sign-extend to ACC_W.
module mac_product #(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [ACC_W-1:0]  prod_ext
);
  logic [DATA_W-1:0] prod_low;

  // Low bits of a signed and an unsigned product are identical.
  assign prod_low = op_a * op_b;
  assign prod_ext = {{DATA_W{prod_low[DATA_W-1]}}, prod_low};
endmodule

// File: rtl/mac_acc_reg.sv
// Accumulator halves; an accepted command outranks a half write.
module mac_acc_reg
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W,
  localparam int N_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  mac_op_e           cmd_op,
  input  logic [ACC_W-1:0]  prod_ext,
  input  logic [N_HALF-1:0] wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    acc_next = acc_q;
    unique case (cmd_op)
      MAC_ADD:  acc_next = acc_q + prod_ext;
      MAC_SUB:  acc_next = acc_q - prod_ext;
      MAC_RDCL: acc_next = '0;
      default:  acc_next = acc_q;
    endcase
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [DATA_W-1:0] half_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        half_q <= '0;
      end else if (cmd_fire) begin
        half_q <= acc_next[h*DATA_W +: DATA_W];
      end else if (wr_en[h]) begin
        half_q <= wr_data;
      end
    end

    assign acc_q[h*DATA_W +: DATA_W] = half_q;
  end
endmodule

// File: rtl/mac_result_stage.sv
// One-entry output register for read-and-clear results.
module mac_result_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_a,
  input  logic [DATA_W-1:0] cmd_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] acc_lo,
  output logic [DATA_W-1:0] acc_hi
);
  localparam int ACC_W = 2 * DATA_W;

  mac_op_e          op;
  logic             fire;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] acc_q;

  assign op        = mac_op_e'(cmd_op);
  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;

  mac_product #(.DATA_W(DATA_W)) u_prod (
    .op_a     (cmd_a),
    .op_b     (cmd_b),
    .prod_ext (prod_ext)
  );

  mac_acc_reg #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .cmd_fire (fire),
    .cmd_op   (op),
    .prod_ext (prod_ext),
    .wr_en    ({wr_hi_en, wr_lo_en}),
    .wr_data  (wr_data),
    .acc_q    (acc_q)
  );

  mac_result_stage #(.DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .load      (fire && (op == MAC_RDCL)),
    .load_data (acc_q[DATA_W-1:0]),
    .out_ready (res_ready),
    .out_valid (res_valid),
    .out_data  (res_data)
  );

  assign acc_lo = acc_q[DATA_W-1:0];
  assign acc_hi = acc_q[ACC_W-1:DATA_W];
endmodule

// File: rtl/mac_acc_checker.sv
module mac_acc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              wr_lo_en,
  input logic              wr_hi_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] acc_lo,
  input logic [DATA_W-1:0] acc_hi
);
  logic acc_fire;
  assign acc_fire = cmd_valid && cmd_ready;

  AST_CLEAR_AFTER_RDCL: assert property (@(posedge clk) disable iff (rst)
    acc_fire && cmd_op == 2'd2 |=> acc_lo == '0 && acc_hi == '0); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data)); // R6

  AST_STALL_READY: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |-> !cmd_ready); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc_fire && !wr_lo_en && !wr_hi_en |=> $stable(acc_lo) && $stable(acc_hi)); // R7

  AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !acc_fire && wr_lo_en && !wr_hi_en |=> acc_lo == $past(wr_data) && $stable(acc_hi)); // R7

  AST_RSVD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    acc_fire && cmd_op == 2'd3 |=> $stable(acc_lo) && $stable(acc_hi)); // R8

  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(acc_fire && cmd_op == 2'd2)); // R9
endmodule

bind mac_acc_unit mac_acc_checker #(.DATA_W(DATA_W)) u_mac_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .wr_lo_en  (wr_lo_en),
  .wr_hi_en  (wr_hi_en),
  .wr_data   (wr_data),
  .acc_lo    (acc_lo),
  .acc_hi    (acc_hi)
);

// File: tb/test_mac_acc_unit.sv
module test_mac_acc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;
  logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] acc_lo, acc_hi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] model = '0;

  // {op[65:64], a[63:32], b[31:0]}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0003, 32'h0000_0005},
    {2'd0, 32'hFFFF_FFFE, 32'h0000_0007},
    {2'd1, 32'h0000_0004, 32'h0000_0004},
    {2'd0, 32'h0001_0000, 32'h0001_0000},
    {2'd0, 32'h0000_8000, 32'h0001_0000},
    {2'd1, 32'hFFFF_FFFF, 32'h0000_0001},
    {2'd2, 32'h0000_0000, 32'h0000_0000},
    {2'd0, 32'h7FFF_FFFF, 32'h0000_0002},
    {2'd1, 32'h1234_5678, 32'h0000_0010},
    {2'd2, 32'h0000_0000, 32'h0000_0000},
    {2'd0, 32'h0000_1234, 32'h0000_5678}
  };

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac_acc_unit i_mac_acc_unit (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
    .acc_lo(acc_lo), .acc_hi(acc_hi)
  );

  function automatic logic [63:0] sext_prod(logic [31:0] a, logic [31:0] b);
    logic signed [63:0] full;
    full = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return {{32{full[31]}}, full[31:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] apply(logic [63:0] m, logic [1:0] op,
                                        logic [31:0] a, logic [31:0] b);
    case (op)
      2'd0:    return m + sext_prod(a, b);
      2'd1:    return m - sext_prod(a, b);
      2'd2:    return 64'd0;
      default: return m;
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic issue(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo_before;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 acc in reset", {acc_hi, acc_lo}, 64'd0);
    check("R1 res_valid in reset", {63'd0, res_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 acc after reset", {acc_hi, acc_lo}, 64'd0);
    check("R1 cmd_ready after reset", {63'd0, cmd_ready}, 64'd1);

    // Vector table: R2, R3, R4, R5 (back-to-back), R10
    for (int i = 0; i < NVEC; i++) begin
      lo_before = model[31:0];
      model = apply(model, VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
      issue(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
      check("R2 R3 R5 vector sum", {acc_hi, acc_lo}, model);
      if (VEC[i][65:64] == 2'd2) begin
        check("R4 result valid", {63'd0, res_valid}, 64'd1);
        check("R4 result data", {32'd0, res_data}, {32'd0, lo_before});
      end
    end

    // R7: half writes
    wr_lo_en = 1'b1; wr_data = 32'hA5A5_0001;
    @(negedge clk); wr_lo_en = 1'b0;
    model = {model[63:32], 32'hA5A5_0001};
    check("R7 low write", {acc_hi, acc_lo}, model);
    wr_hi_en = 1'b1; wr_data = 32'h0BAD_F00D;
    @(negedge clk); wr_hi_en = 1'b0;
    model = {32'h0BAD_F00D, model[31:0]};
    check("R7 high write", {acc_hi, acc_lo}, model);
    wr_lo_en = 1'b1; wr_hi_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_lo_en = 1'b0; wr_hi_en = 1'b0;
    model = 64'hFFFF_FFFF_FFFF_FFFF;
    check("R7 both halves", {acc_hi, acc_lo}, model);

    // R10: wrap past 2^64
    issue(2'd0, 32'd1, 32'd1);
    model = 64'd0;
    check("R10 wrap to zero", {acc_hi, acc_lo}, model);
    issue(2'd1, 32'd1, 32'd2);
    model = 64'hFFFF_FFFF_FFFF_FFFE;
    check("R10 wrap below zero", {acc_hi, acc_lo}, model);

    // R8: command beats half write
    wr_lo_en = 1'b1; wr_hi_en = 1'b1; wr_data = 32'h1111_2222;
    issue(2'd0, 32'd3, 32'd3);
    wr_lo_en = 1'b0; wr_hi_en = 1'b0;
    model = model + 64'd9;
    check("R8 add wins over write", {acc_hi, acc_lo}, model);

    // R9: reserved op, also with an overlapping write (R8)
    wr_lo_en = 1'b1; wr_data = 32'h3333_4444;
    issue(2'd3, 32'd7, 32'd9);
    wr_lo_en = 1'b0;
    check("R9 reserved keeps sum", {acc_hi, acc_lo}, model);
    check("R9 reserved no result", {63'd0, res_valid}, 64'd0);

    // R6: back-pressure on the result port
    res_ready = 1'b0;
    lo_before = model[31:0];
    issue(2'd2, 32'd0, 32'd0);
    model = 64'd0;
    check("R6 cmd_ready low while stalled", {63'd0, cmd_ready}, 64'd0);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_a = 32'd5; cmd_b = 32'd6;
    @(negedge clk);
    check("R6 stalled command ignored", {acc_hi, acc_lo}, model);
    check("R6 result held", {31'd0, res_valid, res_data}, {31'd0, 1'b1, lo_before});
    res_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    model = 64'd30;
    check("R6 command accepted after release", {acc_hi, acc_lo}, model);
    check("R6 result drained", {63'd0, res_valid}, 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule